// File: doc/BRIEF.md
# I2C Byte Shift Engine with Configurable Acknowledge

This block moves one byte at a time over a two-wire serial bus. It generates the serial clock, shifts a byte out or in, and optionally adds a ninth acknowledge clock. Both bus lines use open-drain outputs: a 1 on an output-enable port pulls the line low, and a 0 releases it. An 8-bit control word sets the clock divider code, picks standard or fast timing, sets the acknowledge level the block drives when it receives, and turns the ninth clock on or off.

A controller writes the control word, then pulses `go_tx` with a byte on `tx_data`, or pulses `go_rx`. When `go_rx` comes with `rx_is_addr` set, the block treats the incoming byte as an address. It compares bits 7:1 with `own_addr`, acknowledges only on a match, and reports bit 0 as the read/write flag. Start and stop conditions, arbitration and clock stretching are handled outside the block.

Top module: `i2c_ack_engine`

## Requirements
- R1: Control word fields are: bits 4:0 the divider code, bit 5 fast select, bit 6 the ACK level bit, and bit 7 the ninth-clock enable. Each SCL low and high phase lasts H clock cycles. In standard timing H = (code+1)×4. In fast timing H = (code+1). H is never below 2.
- R2: Fast timing is used only when the parameter `SYS_CLK_HZ` is at least 4 MHz. Below that, bit 5 is ignored and standard timing applies.
- R3: In transmit, data bits go out MSB first. For a 0 bit, `sda_oe` is 1 (line pulled low). For a 1 bit, `sda_oe` is 0.
- R4: While a transfer runs, `sda_oe` changes only while SCL is driven low.
- R5: With bit 7 = 1, a ninth clock follows each byte. In transmit, the block releases SDA on that clock and stores the sampled line level in `ack_level` (0 = acknowledged).
- R6: With bit 7 = 0, exactly eight clocks are issued and `ack_level` stays 1.
- R7: In receive, SDA is sampled when SCL rises. The byte appears on `rx_data` at `done`. For a data byte, on the ninth clock the block pulls SDA low when bit 6 = 0 and releases it when bit 6 = 1.
- R8: For an address byte, the block pulls SDA low on the ninth clock only when bit 6 = 0 and byte bits 7:1 equal `own_addr`. `addr_match` reports the comparison result, and `rw_flag` reports byte bit 0.
- R9: `done` is a single-cycle pulse in the cycle right after the last high phase. In that cycle `busy` is 0, SCL is held low and SDA is released.
- R10: While `busy` is 1, a control write that changes any field other than bit 6 aborts the transfer. In the next cycle `busy` is 0, both lines are released, and no `done` follows.
- R11: While `busy` is 1, a control write that changes only bit 6 lets the transfer finish normally.
- R12: After reset, both lines are released, `busy` and `done` are 0, `ack_level` is 1, and `rx_data` and `addr_match` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 8 | Control word value |
| own_addr | input | 7 | Own 7-bit address for address bytes |
| go_tx | input | 1 | Start a transmit byte (wins over go_rx) |
| go_rx | input | 1 | Start a receive byte |
| rx_is_addr | input | 1 | Receive byte is an address byte |
| tx_data | input | 8 | Byte to transmit |
| sda_in | input | 1 | Level of the SDA line |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-byte pulse |
| rx_data | output | 8 | Last received byte |
| rw_flag | output | 1 | Bit 0 of the last received byte |
| addr_match | output | 1 | Last address byte matched own_addr |
| ack_level | output | 1 | Sampled ninth-clock SDA level |

## Verification
The internal state shows up at the ports quickly when it goes wrong:
- A wrong bit counter changes the number of SCL rises seen before `done`. This is visible at the end of the same byte.
- A shift register that is off by one gives the wrong bus pattern or `rx_data` at the next `done`.
- A faulty divider count changes the length of the first high phase. This is visible within about 2H cycles of the start.
- A missing abort leaves `busy` high in the cycle right after the control write.
- A bad address compare flips the ninth-clock SDA level. This is seen at the ninth rise.

// File: rtl/i2c_ack_pkg.sv
package i2c_ack_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_LOW  = 2'd1,
    S_HIGH = 2'd2
  } seq_st_e;
endpackage

// File: rtl/i2c_ack_divider.sv
module i2c_ack_divider #(
  parameter int CODE_W    = 5,
  parameter int STD_MULT  = 4,
  parameter int FAST_MULT = 1,
  parameter int MIN_HALF  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [CODE_W-1:0] code,
  input  logic              fast,
  output logic              phase_end
);
  localparam int MAXH  = (2**CODE_W) * STD_MULT + MIN_HALF;
  localparam int CNT_W = $clog2(MAXH + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, half, prod;

  always_comb begin
    prod = CNT_W'((32'(code) + 32'd1) * (fast ? FAST_MULT : STD_MULT));
    half = (prod < CNT_W'(MIN_HALF)) ? CNT_W'(MIN_HALF) : prod;
  end

  assign phase_end = run && (cnt_q == half - CNT_W'(1));

  always_comb begin
    if (!run || phase_end) cnt_d = '0;
    else                   cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R1
  phase_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < half));
endmodule

// File: rtl/i2c_ack_addr_cmp.sv
module i2c_ack_addr_cmp #(
  parameter int ADDR_W = 7
) (
  input  logic [ADDR_W-1:0] addr_field,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              is_addr,
  input  logic              ack_bit,
  output logic              match,
  output logic              ack_low
);
  assign match   = (addr_field == own_addr);
  assign ack_low = !ack_bit && (!is_addr || match);
endmodule

// File: rtl/i2c_ack_engine.sv
module i2c_ack_engine
  import i2c_ack_pkg::*;
#(
  parameter int SYS_CLK_HZ  = 20_000_000,
  parameter int FAST_MIN_HZ = 4_000_000,
  parameter int CODE_W      = 5,
  parameter int STD_MULT    = 4,
  parameter int FAST_MULT   = 1,
  parameter int MIN_HALF    = 2,
  parameter int ADDR_W      = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CODE_W+2:0] cfg_wdata,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              go_tx,
  input  logic              go_rx,
  input  logic              rx_is_addr,
  input  logic [ADDR_W:0]   tx_data,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W:0]   rx_data,
  output logic              rw_flag,
  output logic              addr_match,
  output logic              ack_level
);
  localparam int  CFG_W    = CODE_W + 3;
  localparam int  DATA_W   = ADDR_W + 1;
  localparam int  FAST_IDX = CODE_W;
  localparam int  ACK_IDX  = CODE_W + 1;
  localparam int  CLK_IDX  = CODE_W + 2;
  localparam int  BITN_W   = $clog2(DATA_W + 1);
  localparam bit  FAST_OK  = (SYS_CLK_HZ >= FAST_MIN_HZ);
  localparam logic [CFG_W-1:0]  NONACK_MASK = ~(CFG_W'(1) << ACK_IDX);
  localparam logic [BITN_W-1:0] BIT_ACK     = BITN_W'(DATA_W);
  localparam logic [BITN_W-1:0] BIT_LASTD   = BITN_W'(DATA_W - 1);

  seq_st_e            st_q, st_d;
  logic [BITN_W-1:0]  bitn_q, bitn_d, last_bit;
  logic [DATA_W-1:0]  txsh_q, txsh_d, rxsh_q, rxsh_d, rxd_q, rxd_d;
  logic [CFG_W-1:0]   cfg_q, cfg_d;
  logic scl_q, scl_d, sda_q, sda_d, ack_q, ack_d, match_q, match_d;
  logic rxm_q, rxm_d, adr_q, adr_d, done_q, done_d;
  logic fast_eff, phase_end, abort_w, match_w, ack_low;

  generate
    if (FAST_OK) begin : g_fast
      assign fast_eff = cfg_q[FAST_IDX];
    end else begin : g_std_only
      assign fast_eff = 1'b0;
    end
  endgenerate

  assign busy     = (st_q != S_IDLE);
  assign abort_w  = cfg_we && busy && (((cfg_wdata ^ cfg_q) & NONACK_MASK) != '0);
  assign last_bit = cfg_q[CLK_IDX] ? BIT_ACK : BIT_LASTD;

  i2c_ack_divider #(
    .CODE_W(CODE_W), .STD_MULT(STD_MULT), .FAST_MULT(FAST_MULT), .MIN_HALF(MIN_HALF)
  ) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .code(cfg_q[CODE_W-1:0]),
    .fast(fast_eff), .phase_end(phase_end)
  );

  i2c_ack_addr_cmp #(.ADDR_W(ADDR_W)) u_cmp (
    .addr_field(rxsh_q[DATA_W-1:1]), .own_addr(own_addr), .is_addr(adr_q),
    .ack_bit(cfg_q[ACK_IDX]), .match(match_w), .ack_low(ack_low)
  );

  always_comb begin
    st_d = st_q;  bitn_d = bitn_q; txsh_d = txsh_q; rxsh_d = rxsh_q;
    rxd_d = rxd_q; scl_d = scl_q; sda_d = sda_q; ack_d = ack_q;
    match_d = match_q; rxm_d = rxm_q; adr_d = adr_q; done_d = 1'b0;
    cfg_d = cfg_we ? cfg_wdata : cfg_q;
    unique case (st_q)
      S_IDLE: if (go_tx || go_rx) begin
        st_d = S_LOW;  bitn_d = '0;
        rxm_d = !go_tx; adr_d = !go_tx && rx_is_addr;
        txsh_d = tx_data; scl_d = 1'b1;
        sda_d = go_tx && !tx_data[DATA_W-1];
        ack_d = 1'b1; match_d = 1'b0;
      end
      S_LOW: if (phase_end) begin
        st_d = S_HIGH; scl_d = 1'b0;
        if (bitn_q == BIT_ACK) ack_d = sda_in;
        else if (rxm_q)        rxsh_d = {rxsh_q[DATA_W-2:0], sda_in};
      end
      S_HIGH: if (phase_end) begin
        scl_d = 1'b1;
        if (bitn_q == last_bit) begin
          st_d = S_IDLE; done_d = 1'b1; sda_d = 1'b0;
          match_d = adr_q && match_w;
          if (rxm_q) rxd_d = rxsh_q;
        end else begin
          st_d = S_LOW; bitn_d = bitn_q + BITN_W'(1);
          txsh_d = txsh_q << 1;
          if (bitn_q == BIT_LASTD) sda_d = rxm_q && ack_low;
          else                     sda_d = !rxm_q && !txsh_q[DATA_W-2];
        end
      end
      default: st_d = S_IDLE;
    endcase
    if (abort_w) begin
      st_d = S_IDLE; scl_d = 1'b0; sda_d = 1'b0; done_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; bitn_q <= '0; txsh_q <= '0; rxsh_q <= '0; rxd_q <= '0;
      cfg_q <= '0; scl_q <= 1'b0; sda_q <= 1'b0; ack_q <= 1'b1; match_q <= 1'b0;
      rxm_q <= 1'b0; adr_q <= 1'b0; done_q <= 1'b0;
    end else begin
      st_q <= st_d; bitn_q <= bitn_d; txsh_q <= txsh_d; rxsh_q <= rxsh_d; rxd_q <= rxd_d;
      cfg_q <= cfg_d; scl_q <= scl_d; sda_q <= sda_d; ack_q <= ack_d; match_q <= match_d;
      rxm_q <= rxm_d; adr_q <= adr_d; done_q <= done_d;
    end
  end

  assign scl_oe     = scl_q;
  assign sda_oe     = sda_q;
  assign done       = done_q;
  assign rx_data    = rxd_q;
  assign rw_flag    = rxd_q[0];
  assign addr_match = match_q;
  assign ack_level  = ack_q;

  // R4
  sda_quiet_on_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_q && $past(!scl_q) && !$past(abort_w)) |-> $stable(sda_q));
  // R6
  no_ninth_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cfg_q[CLK_IDX]) |-> (bitn_q < BIT_ACK));
  // R8
  addr_miss_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_LOW && bitn_q == BIT_ACK && rxm_q && adr_q && !match_w) |-> !sda_oe);
  // R9
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_w |=> (!busy && !scl_oe && !sda_oe && !done));
endmodule

// File: tb/i2c_ack_engine_tb_top.sv
`timescale 1ns/1ps
module i2c_ack_engine_tb_top;
  localparam logic [6:0] OWN = 7'h51;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       cfg_we = 0, go_tx = 0, go_rx = 0, rx_is_addr = 0;
  logic [7:0] cfg_wdata = 0, tx_data = 0;
  logic       scl_oe, sda_oe, busy, done, rw_flag, addr_match, ack_level, sda_in;
  logic [7:0] rx_data;
  logic       tb_low = 0;
  assign sda_in = !(sda_oe || tb_low);

  i2c_ack_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .own_addr(OWN),
    .go_tx(go_tx), .go_rx(go_rx), .rx_is_addr(rx_is_addr), .tx_data(tx_data),
    .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .done(done),
    .rx_data(rx_data), .rw_flag(rw_flag), .addr_match(addr_match), .ack_level(ack_level)
  );

  // slow-clock variant: fast select must be ignored
  logic       s_we = 0, s_go = 0;
  logic [7:0] s_wdata = 0;
  logic       s_scl_oe, s_sda_oe, s_busy, s_done, s_rw, s_match, s_ack;
  logic [7:0] s_rxd;
  i2c_ack_engine #(.SYS_CLK_HZ(1_000_000)) dut_slow (
    .clk(clk), .rst_n(rst_n), .cfg_we(s_we), .cfg_wdata(s_wdata), .own_addr(OWN),
    .go_tx(s_go), .go_rx(1'b0), .rx_is_addr(1'b0), .tx_data(8'h00),
    .sda_in(!s_sda_oe), .scl_oe(s_scl_oe), .sda_oe(s_sda_oe), .busy(s_busy), .done(s_done),
    .rx_data(s_rxd), .rw_flag(s_rw), .addr_match(s_match), .ack_level(s_ack)
  );

  typedef struct {
    bit rx; int nbits; logic [7:0] data; bit ack9; bit ack_lvl;
    int half; bit match; bit rw; string req;
  } item_t;
  item_t q[$];

  int n_chk = 0, n_fail = 0, r4_bad = 0;
  bit cur_rx = 0, cur_sack = 0;
  logic [7:0] cur_data = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // monitor / scoreboard
  bit prev_scl = 0, prev_sda = 0, prev_done = 0;
  int nrise = 0, hi_run = 0, first_hi = 0;
  logic [8:0] obs = 0;
  always @(negedge clk) begin
    item_t it;
    bit scl_l, sda_l;
    if (!rst_n) begin
      nrise = 0; hi_run = 0; first_hi = 0; obs = 0; tb_low = 0;
      prev_scl = 0; prev_sda = 0; prev_done = 0;
    end else begin
      scl_l = !scl_oe; sda_l = !(sda_oe || tb_low);
      if (busy && prev_scl && scl_l && (sda_oe != prev_sda)) r4_bad++;
      if (busy && !prev_scl && scl_l) begin obs = {obs[7:0], sda_l}; nrise++; end
      if (busy && scl_l) hi_run++;
      if (prev_scl && !scl_l && first_hi == 0 && hi_run > 0) first_hi = hi_run;
      if (prev_done && done) check(0, "R9", "done wider than one cycle", 1, 0);
      if (done) begin
        if (q.size() == 0) check(0, "R10", "unexpected done", 1, 0);
        else begin
          it = q.pop_front();
          check(nrise == it.nbits, it.req, "clock count", nrise, it.nbits);
          check(((it.nbits == 9) ? obs[8:1] : obs[7:0]) == it.data, it.req,
                "bus byte MSB first", int'((it.nbits == 9) ? obs[8:1] : obs[7:0]), it.data);
          if (it.nbits == 9) check(obs[0] == it.ack9, it.req, "ninth-clock SDA", obs[0], it.ack9);
          check(ack_level == it.ack_lvl, it.req, "ack_level", ack_level, it.ack_lvl);
          check(first_hi == it.half, "R1", "high phase cycles", first_hi, it.half);
          check(addr_match == it.match, it.req, "addr_match", addr_match, it.match);
          if (it.rx) begin
            check(rx_data == it.data, it.req, "rx_data", rx_data, it.data);
            check(rw_flag == it.rw, it.req, "rw_flag", rw_flag, it.rw);
          end
          check(!busy && scl_oe && !sda_oe, "R9", "line state at done",
                {busy, scl_oe, sda_oe}, 3'b010);
        end
        nrise = 0; hi_run = 0; first_hi = 0; obs = 0;
      end else if (!busy) begin
        nrise = 0; hi_run = 0; first_hi = 0; obs = 0;
      end
      if (!busy) tb_low = 0;
      else if (!scl_l)
        tb_low = cur_rx ? (nrise < 8 && !cur_data[7 - nrise]) : (nrise == 8 && cur_sack);
      prev_scl = scl_l; prev_sda = sda_oe; prev_done = done;
    end
  end

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk); cfg_we = 1; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic run_xfer(input bit rx, input logic [7:0] d, input bit is_addr,
                          input bit sack, input logic [7:0] cfg, input bit mid_flip,
                          input string req);
    item_t it;
    int h;
    bit okaddr;
    h = (int'(cfg[4:0]) + 1) * (cfg[5] ? 1 : 4);
    if (h < 2) h = 2;
    okaddr = (d[7:1] == OWN);
    it.rx = rx; it.nbits = cfg[7] ? 9 : 8; it.data = d; it.half = h; it.req = req;
    it.ack9 = rx ? !(!cfg[6] && (!is_addr || okaddr)) : !sack;
    it.ack_lvl = cfg[7] ? it.ack9 : 1'b1;
    it.match = rx && is_addr && okaddr;
    it.rw = d[0];
    write_cfg(cfg);
    cur_rx = rx; cur_data = d; cur_sack = sack;
    q.push_back(it);
    @(negedge clk); go_tx = !rx; go_rx = rx; rx_is_addr = is_addr; tx_data = d;
    @(negedge clk); go_tx = 0; go_rx = 0;
    if (mid_flip) begin
      repeat (10) @(negedge clk);
      cfg_we = 1; cfg_wdata = cfg ^ 8'h40;
      @(negedge clk); cfg_we = 0;
    end
    for (int i = 0; i < 4000 && q.size() != 0; i++) @(negedge clk);
    if (q.size() != 0) begin
      check(0, req, "transfer never completed", 0, 1);
      void'(q.pop_front());
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog expired: act=0 exp=1");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    check(!scl_oe && !sda_oe && !busy && !done, "R12", "lines/busy/done after reset",
          {scl_oe, sda_oe, busy, done}, 0);
    check(ack_level && rx_data == 0 && !addr_match, "R12", "status after reset",
          {ack_level, addr_match, rx_data}, 10'h200);
    // R3 R5 transmit with acknowledge, standard code 0
    run_xfer(0, 8'hA5, 0, 1, 8'h80, 0, "R3");
    // R6 no ninth clock
    run_xfer(0, 8'h3C, 0, 1, 8'h00, 0, "R6");
    // R5 fast code 2, slave does not acknowledge
    run_xfer(0, 8'h96, 0, 0, 8'hA2, 0, "R5");
    // R1 fast code 0 floors at minimum
    run_xfer(0, 8'hF0, 0, 1, 8'hA0, 0, "R1");
    // R7 receive data, ack driven
    run_xfer(1, 8'h5A, 0, 0, 8'h81, 0, "R7");
    // R7 receive data, ack bit set -> released
    run_xfer(1, 8'hC3, 0, 0, 8'hC0, 0, "R7");
    // R8 address match, read flag
    run_xfer(1, {OWN, 1'b1}, 1, 0, 8'h80, 0, "R8");
    // R8 address mismatch
    run_xfer(1, 8'h64, 1, 0, 8'h80, 0, "R8");
    // R8 matching address but ack bit set
    run_xfer(1, {OWN, 1'b0}, 1, 0, 8'hC0, 0, "R8");
    // R11 ack-bit-only write during transfer
    run_xfer(0, 8'h69, 0, 1, 8'h82, 1, "R11");
    // R10 abort on divider change
    begin
      int seen_done;
      write_cfg(8'h83);
      cur_rx = 0; cur_data = 8'h55; cur_sack = 0;
      @(negedge clk); go_tx = 1; tx_data = 8'h55;
      @(negedge clk); go_tx = 0;
      repeat (20) @(negedge clk);
      check(busy, "R10", "busy before abort", busy, 1);
      cfg_we = 1; cfg_wdata = 8'h84;
      @(negedge clk); cfg_we = 0;
      check(!busy && !scl_oe && !sda_oe, "R10", "released after abort",
            {busy, scl_oe, sda_oe}, 0);
      seen_done = 0;
      for (int i = 0; i < 300; i++) begin @(negedge clk); if (done) seen_done++; end
      check(seen_done == 0, "R10", "no done after abort", seen_done, 0);
    end
    // R2 slow instance ignores fast select: code 2 gives 12 cycles
    begin
      int lo;
      @(negedge clk); s_we = 1; s_wdata = 8'h22;
      @(negedge clk); s_we = 0; s_go = 1;
      @(negedge clk); s_go = 0;
      lo = 0;
      for (int i = 0; i < 100 && s_scl_oe; i++) begin lo++; @(negedge clk); end
      check(lo == 12, "R2", "slow-clock low phase", lo, 12);
    end
    // R4 SDA never moved while SCL high
    check(r4_bad == 0, "R4", "SDA changes during SCL high", r4_bad, 0);
    repeat (5) @(negedge clk);
    summary();
    $finish;
  end
endmodule